// File: doc/BRIEF.md
# Synchronous Serial Receiver with Auto-Wait

This block receives 8-bit bytes over a clocked serial link. A data input is sampled on the chosen edge of a serial clock and the bits are assembled either most-significant first or least-significant first. The serial clock is generated inside the block from a selectable power-of-two divider of the system clock and driven out on a pin, or it is taken from an external clock input. Each finished byte lands in a receive buffer, sets a done flag and raises a one-cycle interrupt.

Software reaches the block through three byte-wide registers. Address 0 is control, address 1 is status and address 2 is the receive buffer.

The two clock sources differ in how they handle a byte that has not been read. With the internal clock, the block holds its own clock high after every byte until the buffer is read. With an external clock, the sender cannot be held, so reception continues and a byte that finishes over an unread buffer is dropped and flagged. Reception can be halted in three ways: at once, at the end of the current byte, or by an abort that clears any partial byte. Configuration is frozen while the block is busy.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset, the status register reads 0, the buffer reads 0, `irq` is 0 and `sclk_out` is 1.
- R2: The control byte has mode in [1:0], start in [2], edge select in [3], bit order in [4] and clock select in [7:5]. The status byte has busy in [0], shift-enable in [1], receive-done in [2] and overrun in [3]. Writing control with start=1 and mode=2'b10 while idle sets busy and shift-enable.
- R3: While busy, a control write changes neither clock select, bit order nor edge select. Such a write has an effect only when it carries mode=2'b00 or start=0, and control reads back unchanged after any other write.
- R4: Bits are sampled on the rising serial clock edge when edge select is 0 and on the falling edge when it is 1. With bit order 1 the first bit received becomes bit 7; with bit order 0 it becomes bit 0.
- R5: When the eighth bit is sampled, the byte goes to the buffer, receive-done is set and `irq` pulses high for exactly one cycle.
- R6: Clock select values k=0..6 choose the internal clock, with one serial period equal to 2^(k+1) system clock cycles. While no internal reception is running, `sclk_out` rests at 1.
- R7: With the internal clock, a finished byte clears shift-enable and holds `sclk_out` at 1. A read of the buffer sets shift-enable again and restarts the clock.
- R8: Clock select 3'b111 selects the external clock. Reception then continues without waiting for a read. A byte that completes while receive-done is still 1 sets overrun, and the buffer keeps the earlier byte.
- R9: Reading the buffer clears receive-done. Reading status clears overrun.
- R10: Writing start=0 while busy, with shift-enable at 0 or with no bit of the current byte yet sampled, clears busy at once and raises no interrupt.
- R11: Writing start=0 while busy, with shift-enable at 1 and part of a byte sampled, keeps busy until that byte completes. The byte is then stored, `irq` pulses and busy clears.
- R12: Writing mode=2'b00 while busy clears busy and shift-enable and discards the partial byte and bit count, so the next reception starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 receive buffer |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| sclk_in | input | 1 | External serial clock |
| sclk_out | output | 1 | Internally generated serial clock; rests at 1 |
| sd_in | input | 1 | Serial data input |
| irq | output | 1 | One-cycle pulse for each completed byte |

## Verification
The hardest situations to reach are the ones where the block's own progress meets a register access: a stop that arrives after part of a byte has been sampled, and a second external byte that completes over an unread buffer. The bench drives the external clock itself, bit by bit, so it can stop after any chosen bit, issue the stop or abort, and only then send the remaining bits. The internal-clock auto-wait is checked by counting `sclk_out` transitions over a fixed window, once before and once after the buffer read.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned MAX_SEL = 6;
  localparam int unsigned DIV_W   = MAX_SEL + 1;
  localparam int unsigned ADDR_W  = 2;

  localparam logic [1:0] MODE_OFF = 2'b00;
  localparam logic [1:0] MODE_RX  = 2'b10;
  localparam logic [SEL_W-1:0] SEL_EXT = '1;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_BUF  = 2'd2;

  typedef struct packed {
    logic [SEL_W-1:0] clk_sel;
    logic             msb_first;
    logic             edge_fall;
    logic             start;
    logic [1:0]       mode;
  } ctrl_t;

  // Last divider count of one half serial period: 2^sel - 1.
  function automatic logic [DIV_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
    logic [DIV_W:0] span;
    span      = '0;
    span[sel] = 1'b1;
    return DIV_W'(span - {{DIV_W{1'b0}}, 1'b1});
  endfunction

  // Insert one serial bit into the partial byte.
  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic b,
                                                 input logic msb_first);
    return msb_first ? {cur[DATA_W-2:0], b} : {b, cur[DATA_W-1:1]};
  endfunction
endpackage

// File: rtl/srx_clkgen.sv
module srx_clkgen
  import srx_pkg::*;
#(
  parameter int unsigned P_SEL_W = SEL_W,
  parameter int unsigned P_DIV_W = DIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_sel,
  input  logic [P_SEL_W-1:0] clk_sel,
  input  logic               edge_fall,
  input  logic               gen_run,
  input  logic               sclk_in,
  input  logic               sd_in,
  output logic               sclk_out,
  output logic               sample_evt,
  output logic               sd_bit
);
  logic [P_DIV_W-1:0] div_cnt;
  logic               sclk_q;
  logic               gen_active;
  logic               tick;
  logic               int_evt;
  logic [2:0]         ck_sync;
  logic [1:0]         sd_sync;
  logic               ext_rise;
  logic               ext_fall;

  // Once started, the generator always finishes a low phase so it rests high.
  assign gen_active = (gen_run & ~ext_sel) | ~sclk_q;
  assign tick       = gen_active && (div_cnt == div_limit(clk_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      sclk_q  <= 1'b1;
    end else if (!gen_active) begin
      div_cnt <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      sclk_q  <= ~sclk_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_sync <= '0;
      sd_sync <= '0;
    end else begin
      ck_sync <= {ck_sync[1:0], sclk_in};
      sd_sync <= {sd_sync[0], sd_in};
    end
  end

  assign ext_rise   = ck_sync[1] & ~ck_sync[2];
  assign ext_fall   = ~ck_sync[1] & ck_sync[2];
  assign int_evt    = tick & (edge_fall ? sclk_q : ~sclk_q);
  assign sample_evt = ext_sel ? (edge_fall ? ext_fall : ext_rise) : int_evt;
  assign sd_bit     = sd_sync[1];
  assign sclk_out   = sclk_q;

  // R6: with no internal reception running, a high clock output stays high
  a_r6_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_run && sclk_out) |=> sclk_out)
    else $error("a_r6_rest_high");

  // R8: the generated clock stays quiet once the external clock is in use
  a_r8_ext_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_sel && sclk_out) |=> sclk_out)
    else $error("a_r8_ext_quiet");
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int unsigned P_DATA_W = DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_evt,
  input  logic                sample_en,
  input  logic                msb_first,
  input  logic                sd_bit,
  input  logic                clear,
  output logic [P_DATA_W-1:0] rx_byte,
  output logic                byte_done,
  output logic                bits_pending
);
  localparam int unsigned CNT_W = $clog2(P_DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(P_DATA_W - 1);

  logic [P_DATA_W-1:0] shreg;
  logic [CNT_W-1:0]    bit_cnt;
  logic                take;

  assign take         = sample_evt & sample_en;
  assign rx_byte      = shift_in(shreg, sd_bit, msb_first);
  assign byte_done    = take && (bit_cnt == LAST_BIT);
  assign bits_pending = (bit_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (take) begin
      shreg   <= rx_byte;
      bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
    end
  end

  // R5: the bit count restarts after each completed byte
  a_r5_count_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !bits_pending)
    else $error("a_r5_count_wrap");

  // R12: an abort or immediate stop leaves no partial byte behind
  a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (!bits_pending && shreg == '0))
    else $error("a_r12_clear");
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              bits_pending,
  output logic              busy,
  output logic              shift_en,
  output logic              ext_sel,
  output logic [SEL_W-1:0]  clk_sel,
  output logic              edge_fall,
  output logic              msb_first,
  output logic              clr_shift,
  output logic              irq
);
  ctrl_t             cfg_q;
  ctrl_t             wr_v;
  logic [DATA_W-1:0] buf_q;
  logic              busy_q, shift_en_q, stop_pend_q, rx_done_q, overrun_q, irq_q;

  logic wr_ctrl, rd_buf, rd_stat;
  logic do_begin, do_abort, do_halt, halt_now, halt_later;
  logic rx_unread, overrun_evt, store_evt, finish_stop;

  assign wr_v    = ctrl_t'(reg_wdata);
  assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
  assign rd_buf  = reg_rd && (reg_addr == ADDR_BUF);
  assign rd_stat = reg_rd && (reg_addr == ADDR_STAT);

  assign do_begin   = wr_ctrl && !busy_q && wr_v.start && (wr_v.mode == MODE_RX);
  assign do_abort   = wr_ctrl && busy_q && (wr_v.mode == MODE_OFF);
  assign do_halt    = wr_ctrl && busy_q && !do_abort && !wr_v.start;
  assign halt_now   = do_halt && (!shift_en_q || !bits_pending);
  assign halt_later = do_halt && !halt_now;

  assign rx_unread   = rx_done_q && !rd_buf;
  assign overrun_evt = byte_done && ext_sel && rx_unread;
  assign store_evt   = byte_done && !overrun_evt;
  assign finish_stop = byte_done && (stop_pend_q || halt_later);
  assign clr_shift   = do_abort | halt_now;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_ctrl && !busy_q) begin
      cfg_q       <= wr_v;
      cfg_q.start <= do_begin;
    end else if (do_abort) begin
      cfg_q.mode  <= MODE_OFF;
      cfg_q.start <= 1'b0;
    end else if (do_halt) begin
      cfg_q.start <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      shift_en_q  <= 1'b0;
      stop_pend_q <= 1'b0;
    end else begin
      if (do_begin) begin
        busy_q      <= 1'b1;
        shift_en_q  <= 1'b1;
        stop_pend_q <= 1'b0;
      end
      if (halt_later) stop_pend_q <= 1'b1;
      if (rd_buf && busy_q && !ext_sel && !shift_en_q && !byte_done) shift_en_q <= 1'b1;
      if (byte_done && !ext_sel) shift_en_q <= 1'b0;
      if (finish_stop) begin
        busy_q      <= 1'b0;
        shift_en_q  <= 1'b0;
        stop_pend_q <= 1'b0;
      end
      if (clr_shift) begin
        busy_q      <= 1'b0;
        shift_en_q  <= 1'b0;
        stop_pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      rx_done_q <= 1'b0;
      overrun_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= byte_done;
      if (rd_buf)      rx_done_q <= 1'b0;
      if (rd_stat)     overrun_q <= 1'b0;
      if (overrun_evt) overrun_q <= 1'b1;
      if (store_evt) begin
        buf_q     <= rx_byte;
        rx_done_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = cfg_q;
      ADDR_STAT: reg_rdata = {4'b0000, overrun_q, rx_done_q, shift_en_q, busy_q};
      ADDR_BUF:  reg_rdata = buf_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign busy      = busy_q;
  assign shift_en  = shift_en_q;
  assign clk_sel   = cfg_q.clk_sel;
  assign ext_sel   = (cfg_q.clk_sel == SEL_EXT);
  assign edge_fall = cfg_q.edge_fall;
  assign msb_first = cfg_q.msb_first;
  assign irq       = irq_q;

  // R2: a valid start makes the block busy with shifting enabled
  a_r2_begin: assert property (@(posedge clk) disable iff (!rst_n)
    do_begin |=> (busy && shift_en))
    else $error("a_r2_begin");

  // R3: transfer settings cannot change while busy
  a_r3_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable({cfg_q.clk_sel, cfg_q.msb_first, cfg_q.edge_fall}))
    else $error("a_r3_cfg_locked");

  // R5: the interrupt is a single-cycle pulse
  a_r5_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq)
    else $error("a_r5_irq_pulse");

  // R7: internal clock waits after each byte
  a_r7_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !ext_sel) |=> !shift_en)
    else $error("a_r7_wait");

  // R8: a byte over an unread buffer flags overrun and is dropped
  a_r8_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && ext_sel && rx_done_q && !rd_buf) |=> (overrun_q && $stable(buf_q)))
    else $error("a_r8_overrun_keeps");

  // R10: an immediate stop ends at once without an interrupt
  a_r10_quiet_stop: assert property (@(posedge clk) disable iff (!rst_n)
    halt_now |=> (!busy && !irq))
    else $error("a_r10_quiet_stop");

  // R11: a deferred stop ends with the completing byte and its interrupt
  a_r11_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stop_pend_q && byte_done) |=> (!busy && irq))
    else $error("a_r11_deferred");
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
  import srx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sclk_in,
  output logic       sclk_out,
  input  logic       sd_in,
  output logic       irq
);
  logic              busy, shift_en, ext_sel, edge_fall, msb_first, clr_shift;
  logic [SEL_W-1:0]  clk_sel;
  logic              sample_evt, sd_bit, byte_done, bits_pending, run;
  logic [DATA_W-1:0] rx_byte;

  assign run = busy & shift_en;

  srx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .byte_done(byte_done), .rx_byte(rx_byte), .bits_pending(bits_pending),
    .busy(busy), .shift_en(shift_en), .ext_sel(ext_sel), .clk_sel(clk_sel),
    .edge_fall(edge_fall), .msb_first(msb_first), .clr_shift(clr_shift),
    .irq(irq)
  );

  srx_clkgen u_clkgen (
    .clk(clk), .rst_n(rst_n),
    .ext_sel(ext_sel), .clk_sel(clk_sel), .edge_fall(edge_fall),
    .gen_run(run), .sclk_in(sclk_in), .sd_in(sd_in),
    .sclk_out(sclk_out), .sample_evt(sample_evt), .sd_bit(sd_bit)
  );

  srx_shifter u_shifter (
    .clk(clk), .rst_n(rst_n),
    .sample_evt(sample_evt), .sample_en(run), .msb_first(msb_first),
    .sd_bit(sd_bit), .clear(clr_shift),
    .rx_byte(rx_byte), .byte_done(byte_done), .bits_pending(bits_pending)
  );
endmodule

// File: tb/sync_serial_rx_tb_top.sv
`timescale 1ns/1ps
module sync_serial_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       sclk_in = 1'b0, sd_in = 1'b0;
  logic       sclk_out, irq;

  int checks = 0, failures = 0, irq_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sync_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sd_in(sd_in), .irq(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  // Vector: [15:8] byte, [7:5] clock select, [4] msb first, [3] falling edge
  localparam logic [15:0] VEC [4] = '{
    {8'hA5, 3'b111, 1'b1, 1'b0, 3'b000},
    {8'h3C, 3'b111, 1'b0, 1'b1, 3'b000},
    {8'h96, 3'b010, 1'b0, 1'b0, 3'b000},
    {8'h5A, 3'b010, 1'b1, 1'b1, 3'b000}
  };

  function automatic logic [7:0] ctl(input logic [2:0] sel, input logic msb,
                                     input logic efall, input logic st,
                                     input logic [1:0] md);
    return {sel, msb, efall, st, md};
  endfunction

  function automatic int bit_idx(input logic msb, input int i);
    return msb ? 7 - i : i;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic send_ext(input logic [7:0] data, input logic msb, input logic efall,
                          input int first, input int last);
    for (int i = first; i <= last; i++) begin
      sd_in = data[bit_idx(msb, i)];
      repeat (4) @(posedge clk);
      sclk_in = !efall;
      repeat (4) @(posedge clk);
      sclk_in = efall;
      repeat (4) @(posedge clk);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic send_int(input logic [7:0] data, input logic [2:0] sel,
                          input logic msb, input logic efall);
    sd_in = data[bit_idx(msb, 0)];
    wr_reg(2'd0, ctl(sel, msb, efall, 1'b1, 2'b10));
    for (int i = 0; i < 8; i++) begin
      if (efall) @(negedge sclk_out); else @(posedge sclk_out);
      #1;
      if (i < 7) sd_in = data[bit_idx(msb, i + 1)];
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic count_toggles(input int cycles, output int n);
    logic prev;
    n = 0;
    prev = sclk_out;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sclk_out != prev) n++;
      prev = sclk_out;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int base, n;
    realtime t0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1 reset state
    rd_reg(2'd1, d); chk("R1 status", d, 0);
    rd_reg(2'd2, d); chk("R1 buffer", d, 0);
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 irq", irq_cnt, 0);

    // Table: R4/R5 byte assembly, R10 immediate stop, R9 read clear
    foreach (VEC[v]) begin
      logic [7:0] data;
      logic [2:0] sel;
      logic msb, efall, ext;
      data = VEC[v][15:8]; sel = VEC[v][7:5]; msb = VEC[v][4]; efall = VEC[v][3];
      ext = (sel == 3'b111);
      sclk_in = efall;
      repeat (4) @(posedge clk);
      base = irq_cnt;
      if (ext) begin
        wr_reg(2'd0, ctl(sel, msb, efall, 1'b1, 2'b10));
        rd_reg(2'd1, d); chk("R2 busy and shift-enable", d, 8'h03);
        send_ext(data, msb, efall, 0, 7);
      end else begin
        send_int(data, sel, msb, efall);
      end
      rd_reg(2'd1, d); chk("R5 status after byte", d, ext ? 8'h07 : 8'h05);
      chk("R5 one irq", irq_cnt, base + 1);
      wr_reg(2'd0, ctl(sel, msb, efall, 1'b0, 2'b10));
      repeat (4) @(posedge clk);
      rd_reg(2'd1, d); chk("R10 stopped at once", d, 8'h04);
      chk("R10 no irq", irq_cnt, base + 1);
      rd_reg(2'd2, d); chk("R4 received byte", d, data);
      rd_reg(2'd1, d); chk("R9 done cleared by buffer read", d, 0);
    end

    // R3 configuration lock
    sclk_in = 1'b0;
    repeat (4) @(posedge clk);
    wr_reg(2'd0, ctl(3'b111, 1'b1, 1'b0, 1'b1, 2'b10));
    wr_reg(2'd0, ctl(3'b000, 1'b0, 1'b1, 1'b1, 2'b10));
    rd_reg(2'd0, d); chk("R3 control unchanged", d, ctl(3'b111, 1'b1, 1'b0, 1'b1, 2'b10));

    // R8 overrun with external clock
    send_ext(8'h11, 1'b1, 1'b0, 0, 7);
    send_ext(8'h22, 1'b1, 1'b0, 0, 7);
    rd_reg(2'd1, d); chk("R8 overrun flagged", d, 8'h0F);
    rd_reg(2'd1, d); chk("R9 overrun cleared by status read", d, 8'h07);
    rd_reg(2'd2, d); chk("R8 buffer keeps first byte", d, 8'h11);
    rd_reg(2'd1, d); chk("R9 done cleared", d, 8'h03);

    // R11 deferred stop mid-byte
    send_ext(8'h6B, 1'b1, 1'b0, 0, 3);
    wr_reg(2'd0, ctl(3'b111, 1'b1, 1'b0, 1'b0, 2'b10));
    repeat (2) @(posedge clk);
    rd_reg(2'd1, d); chk("R11 still busy", d, 8'h03);
    base = irq_cnt;
    send_ext(8'h6B, 1'b1, 1'b0, 4, 7);
    rd_reg(2'd1, d); chk("R11 idle after byte", d, 8'h04);
    chk("R11 irq on completion", irq_cnt, base + 1);
    rd_reg(2'd2, d); chk("R11 byte stored", d, 8'h6B);

    // R12 abort discards partial byte
    wr_reg(2'd0, ctl(3'b111, 1'b1, 1'b0, 1'b1, 2'b10));
    send_ext(8'hFF, 1'b1, 1'b0, 0, 2);
    wr_reg(2'd0, ctl(3'b111, 1'b1, 1'b0, 1'b1, 2'b00));
    rd_reg(2'd1, d); chk("R12 abort idle", d, 0);
    wr_reg(2'd0, ctl(3'b111, 1'b1, 1'b0, 1'b1, 2'b10));
    send_ext(8'hC3, 1'b1, 1'b0, 0, 7);
    rd_reg(2'd2, d); chk("R12 fresh byte after abort", d, 8'hC3);
    wr_reg(2'd0, ctl(3'b111, 1'b1, 1'b0, 1'b0, 2'b10));
    repeat (4) @(posedge clk);

    // R7 auto-wait with internal clock
    send_int(8'h81, 3'b001, 1'b0, 1'b0);
    rd_reg(2'd1, d); chk("R7 waiting status", d, 8'h05);
    count_toggles(40, n); chk("R7 clock held", n, 0);
    chk("R7 clock held high", sclk_out, 1);
    rd_reg(2'd2, d); chk("R7 byte", d, 8'h81);
    count_toggles(20, n); chk("R7 clock resumes", (n > 0) ? 1 : 0, 1);
    wr_reg(2'd0, ctl(3'b001, 1'b0, 1'b0, 1'b1, 2'b00));
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk("R6 rests high after abort", sclk_out, 1);
    rd_reg(2'd1, d); chk("R12 abort from internal run", d, 0);

    // R6 divider period for k=3: 16 system cycles
    wr_reg(2'd0, ctl(3'b011, 1'b1, 1'b0, 1'b1, 2'b10));
    @(posedge sclk_out); t0 = $realtime;
    @(posedge sclk_out);
    chk("R6 serial period", int'(($realtime - t0) / 5.0), 16);
    wr_reg(2'd0, ctl(3'b011, 1'b1, 1'b0, 1'b1, 2'b00));
    repeat (40) @(posedge clk);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule